// File: doc/BRIEF.md
# Fault Shutdown and Interrupt Controller

This block gathers fault and event flags from a power-management controller, keeps them as sticky status bits behind per-event enables, and drives an active-low interrupt pin. A host reaches its registers through a simple single-cycle read/write port. Reading a status register clears it. Two temperature pre-warning flags have their own status register. They are only recorded and never pull the pin.

A second set of enables decides which faults force a power-off. Hold failure, reboot restart and a power-off command written by software always force a power-off. A two-state machine owns the power-off request. In state `ST_ON` it watches for a shutdown trigger and moves to `ST_OFF` (transition *shutdown*), latching a 4-bit cause code. In `ST_OFF` it holds the request and ignores further triggers until the rail controller reports `restart`, which takes it back to `ST_ON` (transition *resume*). The cause register keeps only the latest cause and is cleared only by the power-on reset `por_n`.

Top module: `pmic_fault_ctrl`

## Requirements
- R1: A read (`rd_en`=1) of the main status register (address 1) or the warning status register (address 3) clears that register on the next clock edge. `rdata` is combinational from `addr` and the current register contents. Address 0 is the main enable, 2 the warning enable (bits 1:0), 4 the shutdown enable (bits 6:0), 5 the cause (bits 3:0). Other addresses and unused bits read 0.
- R2: A `fault_ev` or `warn_ev` bit whose enable bit is 0 does not set its status bit. The main status bit map follows `fault_ev`: bit0 input low, bits1-4 buck1-buck4 low, bit5 key long press, bit6 over-temperature, bit7 key short press.
- R3: If an enabled event arrives in the same cycle as a read of its status register, its status bit is set after that edge.
- R4: `irq_n` is 0 exactly when some main status bit and its enable bit are both 1.
- R5: Warning status bits never affect `irq_n`.
- R6: The shutdown enable (address 4) gates `fault_ev[6:0]` bit for bit as shutdown triggers. Its reset value is 0x60, so only key long press and over-temperature are enabled.
- R7: In `ST_ON`, any trigger moves the machine to `ST_OFF` on the next edge, and `off_req` is 1 exactly in `ST_OFF`. `restart`=1 in `ST_OFF` returns it to `ST_ON`. Triggers are an enabled shutdown fault, `hold_fail`, `reboot_req`, or a write to address 6 with `wdata[0]`=1.
- R8: On the shutdown transition the cause becomes: 0000 input low, 0001/0010/0011 buck1/2/3 low, 1000 buck4 low, 0100 key forced, 0101 register command, 0110 over-temperature, 0111 reboot, 1001 hold failure. It resets to 1111.
- R9: When several triggers are present in one cycle, the recorded cause follows this order, highest first: over-temperature, input low, buck1, buck2, buck3, buck4, key, hold failure, reboot, register command.
- R10: In `ST_OFF` the cause does not change, whatever triggers arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset |
| fault_ev | input | 8 | Main fault/event flags, bit map as in R2 |
| warn_ev | input | 2 | Temperature pre-warning flags |
| reboot_req | input | 1 | Reboot restart trigger |
| hold_fail | input | 1 | Power hold failure trigger |
| restart | input | 1 | Rail controller reports power back on |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq_n | output | 1 | Active-low interrupt, open-drain style |
| off_req | output | 1 | Power-off request |
| off_cause | output | 4 | Latest power-off cause code |

## Verification
The bench targets a read that lands in the same cycle as a new event. A design that clears first would lose the event. It also drives pre-warnings with their enables set: if they leaked into the interrupt term, the pin would fall. Simultaneous triggers, such as over-temperature with buck1, or hold failure with reboot, expose a wrong priority order as a wrong cause code. Triggers that arrive during `ST_OFF` would overwrite the cause in a design that latches on every trigger. A behavioural model then runs beside the block under random traffic and compares every output on every cycle.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    parameter int DW     = 8;
    parameter int AW     = 3;
    parameter int EV_W   = 8;
    parameter int WARN_W = 2;
    parameter int SD_W   = 7;
    parameter int CW     = 4;

    localparam logic [AW-1:0] A_EN_MAIN  = 3'd0;
    localparam logic [AW-1:0] A_ST_MAIN  = 3'd1;
    localparam logic [AW-1:0] A_EN_WARN  = 3'd2;
    localparam logic [AW-1:0] A_ST_WARN  = 3'd3;
    localparam logic [AW-1:0] A_SD_EN    = 3'd4;
    localparam logic [AW-1:0] A_CAUSE    = 3'd5;
    localparam logic [AW-1:0] A_CMD      = 3'd6;

    localparam logic [SD_W-1:0] SD_EN_RST = 7'h60;

    typedef enum logic [CW-1:0] {
        OC_VIN    = 4'h0,
        OC_BUCK1  = 4'h1,
        OC_BUCK2  = 4'h2,
        OC_BUCK3  = 4'h3,
        OC_KEY    = 4'h4,
        OC_REGCMD = 4'h5,
        OC_OT     = 4'h6,
        OC_REBOOT = 4'h7,
        OC_BUCK4  = 4'h8,
        OC_HOLD   = 4'h9,
        OC_NONE   = 4'hF
    } off_cause_e;

    typedef enum logic {ST_ON = 1'b0, ST_OFF = 1'b1} pwr_state_e;
endpackage

// File: rtl/pfc_evlatch.sv
module pfc_evlatch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] en,
    input  logic         clr,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                stat[i] <= 1'b0;
            else
                stat[i] <= (stat[i] & ~clr) | (ev[i] & en[i]);
        end

        // R2: a bit only rises when its event was present and enabled
        a_r2_rise_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
            (!$past(stat[i]) && stat[i]) |-> $past(ev[i] && en[i]));
        // R1: a read without a new event clears the bit
        a_r1_read_clears: assert property (@(posedge clk) disable iff (!por_n)
            (clr && !(ev[i] && en[i])) |=> !stat[i]);
        // R3: a coincident enabled event survives the read
        a_r3_event_kept: assert property (@(posedge clk) disable iff (!por_n)
            (clr && ev[i] && en[i]) |=> stat[i]);
    end
endmodule

// File: rtl/pfc_offctl.sv
module pfc_offctl
    import pfc_pkg::*;
(
    input  logic            clk,
    input  logic            por_n,
    input  logic [SD_W-1:0] sd_ev,
    input  logic [SD_W-1:0] sd_en,
    input  logic            reboot_req,
    input  logic            hold_fail,
    input  logic            reg_off,
    input  logic            restart,
    output logic            off_req,
    output logic [CW-1:0]   cause
);
    pwr_state_e     state, state_nx;
    logic [SD_W-1:0] hits;
    logic           trig;
    off_cause_e     pick;

    assign hits = sd_ev & sd_en;
    assign trig = (|hits) | hold_fail | reboot_req | reg_off;

    always_comb begin
        if      (hits[6])    pick = OC_OT;
        else if (hits[0])    pick = OC_VIN;
        else if (hits[1])    pick = OC_BUCK1;
        else if (hits[2])    pick = OC_BUCK2;
        else if (hits[3])    pick = OC_BUCK3;
        else if (hits[4])    pick = OC_BUCK4;
        else if (hits[5])    pick = OC_KEY;
        else if (hold_fail)  pick = OC_HOLD;
        else if (reboot_req) pick = OC_REBOOT;
        else                 pick = OC_REGCMD;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ON:  if (trig)    state_nx = ST_OFF;
            ST_OFF: if (restart) state_nx = ST_ON;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_ON;
            cause <= OC_NONE;
        end else begin
            state <= state_nx;
            if (state == ST_ON && trig)
                cause <= pick;
        end
    end

    always_comb begin
        off_req = (state == ST_OFF);
    end

    // R7: a trigger while on leads to the off state
    a_r7_trigger_shuts: assert property (@(posedge clk) disable iff (!por_n)
        (!off_req && trig) |=> off_req);
    // R10: while off and not restarting, the request and cause hold
    a_r10_off_holds: assert property (@(posedge clk) disable iff (!por_n)
        (off_req && !restart) |=> (off_req && $stable(cause)));
    // R8: cause only moves on entry to the off state
    a_r8_cause_on_entry: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(cause) |-> $rose(off_req));
endmodule

// File: rtl/pmic_fault_ctrl.sv
module pmic_fault_ctrl
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [EV_W-1:0]   fault_ev,
    input  logic [WARN_W-1:0] warn_ev,
    input  logic              reboot_req,
    input  logic              hold_fail,
    input  logic              restart,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq_n,
    output logic              off_req,
    output logic [CW-1:0]     off_cause
);
    logic [EV_W-1:0]   en_main, st_main;
    logic [WARN_W-1:0] en_warn, st_warn;
    logic [SD_W-1:0]   sd_en;
    logic              clr_main, clr_warn, reg_off;

    assign clr_main = rd_en && (addr == A_ST_MAIN);
    assign clr_warn = rd_en && (addr == A_ST_WARN);
    assign reg_off  = wr_en && (addr == A_CMD) && wdata[0];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_main <= '0;
            en_warn <= '0;
            sd_en   <= SD_EN_RST;
        end else if (wr_en) begin
            if (addr == A_EN_MAIN) en_main <= wdata;
            if (addr == A_EN_WARN) en_warn <= wdata[WARN_W-1:0];
            if (addr == A_SD_EN)   sd_en   <= wdata[SD_W-1:0];
        end
    end

    pfc_evlatch #(.W(EV_W)) u_main (
        .clk(clk), .por_n(por_n), .ev(fault_ev), .en(en_main),
        .clr(clr_main), .stat(st_main));

    pfc_evlatch #(.W(WARN_W)) u_warn (
        .clk(clk), .por_n(por_n), .ev(warn_ev), .en(en_warn),
        .clr(clr_warn), .stat(st_warn));

    pfc_offctl u_off (
        .clk(clk), .por_n(por_n), .sd_ev(fault_ev[SD_W-1:0]), .sd_en(sd_en),
        .reboot_req(reboot_req), .hold_fail(hold_fail), .reg_off(reg_off),
        .restart(restart), .off_req(off_req), .cause(off_cause));

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_EN_MAIN: rdata = en_main;
            A_ST_MAIN: rdata = st_main;
            A_EN_WARN: rdata[WARN_W-1:0] = en_warn;
            A_ST_WARN: rdata[WARN_W-1:0] = st_warn;
            A_SD_EN:   rdata[SD_W-1:0] = sd_en;
            A_CAUSE:   rdata[CW-1:0] = off_cause;
            default:   rdata = '0;
        endcase
    end

    assign irq_n = ~|(st_main & en_main);

    // R5: a newly set warning bit leaves the pin alone when no main cause is pending
    a_r5_warn_quiet: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(|st_warn) && (st_main == '0)) |-> irq_n);
endmodule

// File: tb/pmic_fault_ctrl_tb.sv
`timescale 1ns/1ps
module pmic_fault_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [7:0] fault_ev = '0;
    logic [1:0] warn_ev = '0;
    logic       reboot_req = 0, hold_fail = 0, restart = 0;
    logic       wr_en = 0, rd_en = 0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n, off_req;
    logic [3:0] off_cause;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pmic_fault_ctrl dut_i (
        .clk(clk), .por_n(por_n), .fault_ev(fault_ev), .warn_ev(warn_ev),
        .reboot_req(reboot_req), .hold_fail(hold_fail), .restart(restart),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n), .off_req(off_req), .off_cause(off_cause));

    // behavioural reference model
    bit [7:0] m_en, m_st;
    bit [1:0] m_wen, m_wst;
    bit [6:0] m_sd;
    bit       m_off;
    bit [3:0] m_cause;

    always @(posedge clk) begin
        if (!por_n) begin
            m_en = 0; m_st = 0; m_wen = 0; m_wst = 0;
            m_sd = 7'h60; m_off = 0; m_cause = 4'hF;
        end else begin
            bit [6:0] h;
            bit cmd;
            h = fault_ev[6:0] & m_sd;
            cmd = wr_en && addr == 3'd6 && wdata[0];
            if (rd_en && addr == 3'd1) m_st = 0;
            if (rd_en && addr == 3'd3) m_wst = 0;
            m_st  = m_st | (fault_ev & m_en);
            m_wst = m_wst | (warn_ev & m_wen);
            if (m_off) begin
                if (restart) m_off = 0;
            end else if (h != 0 || hold_fail || reboot_req || cmd) begin
                m_off = 1;
                if (h[6])           m_cause = 4'h6;
                else if (h[0])      m_cause = 4'h0;
                else if (h[1])      m_cause = 4'h1;
                else if (h[2])      m_cause = 4'h2;
                else if (h[3])      m_cause = 4'h3;
                else if (h[4])      m_cause = 4'h8;
                else if (h[5])      m_cause = 4'h4;
                else if (hold_fail) m_cause = 4'h9;
                else if (reboot_req) m_cause = 4'h7;
                else                m_cause = 4'h5;
            end
            if (wr_en) begin
                if (addr == 3'd0) m_en  = wdata;
                if (addr == 3'd2) m_wen = wdata[1:0];
                if (addr == 3'd4) m_sd  = wdata[6:0];
            end
        end
    end

    function automatic bit [7:0] m_rdata(input bit [2:0] a);
        case (a)
            3'd0: return m_en;
            3'd1: return m_st;
            3'd2: return {6'd0, m_wen};
            3'd3: return {6'd0, m_wst};
            3'd4: return {1'b0, m_sd};
            3'd5: return {4'd0, m_cause};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (por_n && !finished) begin
            chk("R4 irq_n", irq_n, (m_st & m_en) == 0);
            chk("R7 off_req", off_req, m_off);
            chk("R8 off_cause", off_cause, m_cause);
            chk((addr == 3'd1 || addr == 3'd3) ? "R2 status rdata" : "R1 rdata",
                rdata, m_rdata(addr));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        fault_ev = 0; warn_ev = 0; reboot_req = 0; hold_fail = 0; restart = 0;
        wr_en = 0; rd_en = 0; wdata = 0;
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        wr_en = 1; addr = a; wdata = d; step(); idle_inputs();
    endtask

    task automatic look(input bit [2:0] a);
        addr = a; @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 por_n = 1;
        step();
        // reset state
        look(3'd4); chk("R6 shutdown enable reset", rdata, 8'h60);
        look(3'd5); chk("R8 cause reset", rdata, 8'h0F);
        chk("R4 irq_n reset", irq_n, 1);
        chk("R7 off_req reset", off_req, 0);
        // R2: disabled event is not captured
        step(); fault_ev = 8'h80; step(); idle_inputs();
        look(3'd1); chk("R2 disabled event ignored", rdata, 8'h00);
        chk("R2 pin idle", irq_n, 1);
        step(); wr(3'd0, 8'hFF);
        fault_ev = 8'h80; step(); idle_inputs();
        look(3'd1); chk("R4 pin asserted", irq_n, 0);
        // R3: read coinciding with a new event
        step(); rd_en = 1; addr = 3'd1; fault_ev = 8'h80; step(); idle_inputs();
        look(3'd1); chk("R3 event kept over read", rdata, 8'h80);
        step(); rd_en = 1; addr = 3'd1; step(); idle_inputs();
        look(3'd1); chk("R1 read clears", rdata, 8'h00);
        chk("R4 pin released", irq_n, 1);
        // R5: warnings never drive the pin
        step(); wr(3'd2, 8'h03);
        warn_ev = 2'b11; step(); idle_inputs();
        look(3'd3); chk("R5 warn status set", rdata, 8'h03);
        chk("R5 warn no pin", irq_n, 1);
        step(); rd_en = 1; addr = 3'd3; step(); idle_inputs();
        look(3'd3); chk("R1 warn read clears", rdata, 8'h00);
        // R6: disabled shutdown faults do nothing
        step(); wr(3'd4, 8'h00);
        fault_ev = 8'h7F; step(); idle_inputs();
        look(3'd5); chk("R6 disabled no shutdown", off_req, 0);
        chk("R6 cause untouched", rdata, 8'h0F);
        step(); rd_en = 1; addr = 3'd1; step(); idle_inputs();
        // R9: priority, over-temperature beats buck1
        step(); wr(3'd4, 8'h7F);
        fault_ev = 8'h42; step(); idle_inputs();
        look(3'd5); chk("R7 shutdown taken", off_req, 1);
        chk("R9 OT over buck1", rdata, 8'h06);
        // R10: ignored while off
        step(); fault_ev = 8'h01; hold_fail = 1; step(); idle_inputs();
        look(3'd5); chk("R10 cause held while off", rdata, 8'h06);
        step(); restart = 1; step(); idle_inputs();
        look(3'd5); chk("R7 resume", off_req, 0);
        // R9: hold failure beats reboot
        step(); hold_fail = 1; reboot_req = 1; step(); idle_inputs();
        look(3'd5); chk("R9 hold over reboot", rdata, 8'h09);
        step(); restart = 1; step(); idle_inputs();
        // R8: register command and buck4 codes
        step(); wr(3'd6, 8'h01);
        look(3'd5); chk("R8 register command code", rdata, 8'h05);
        step(); restart = 1; step(); idle_inputs();
        fault_ev = 8'h10; step(); idle_inputs();
        look(3'd5); chk("R8 buck4 code", rdata, 8'h08);
        step(); restart = 1; step(); idle_inputs();
        // random traffic, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            idle_inputs();
            if ($urandom_range(0, 9) == 0) fault_ev = 8'($urandom);
            else if ($urandom_range(0, 3) == 0) fault_ev = 8'h80;
            if ($urandom_range(0, 7) == 0) warn_ev = 2'($urandom);
            reboot_req = ($urandom_range(0, 40) == 0);
            hold_fail  = ($urandom_range(0, 40) == 0);
            restart    = ($urandom_range(0, 5) == 0);
            addr  = 3'($urandom);
            wr_en = ($urandom_range(0, 7) == 0);
            rd_en = ($urandom_range(0, 3) == 0);
            wdata = 8'($urandom);
            step();
        end
        idle_inputs();
        step();
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule